// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes one DDR3 channel from power-up to a state where normal traffic can begin. After a start strobe it opens an init phase, holds the memory reset for a fixed time, releases the reset and waits again, then raises CKE while the command bus stays idle. After that it writes the four mode registers of each rank to be programmed and calibrates the output drivers with ZQ calibration-long commands. Every wall-clock delay is given in nanoseconds and converted to clock cycles through a clock-period parameter.

The mode-register contents are built from configuration inputs: CAS latency, CAS write latency, write recovery, burst control, drive strength, nominal and dynamic termination, self-refresh options, MPR fields, output disable and TDQS. Per-rank rules turn nominal termination off depending on how many DIMMs the channel supports and on which DIMMs are quad-rank. Registered DIMMs have every present rank programmed inside the init phase. With unbuffered DIMMs only the lowest present rank is programmed inside the init phase, and the other ranks are programmed after the init phase ends. A done flag marks completion and stays high until the next start.

Top module: `ddr3_init_seq`

## Requirements
- R1: Out of reset and before the first start: mem_rst_n_o=0, cke_o=0, init_en_o=0, done_o=0, and no command is issued.
- R2: A start seen in idle raises init_en_o and drives mem_rst_n_o low at once. mem_rst_n_o rises N_INIT cycles after the start edge (N = ceil(ns*1000/CLK_PERIOD_PS)).
- R3: cke_o rises N_RST cycles after mem_rst_n_o rises. The first command comes N_INIT+N_RST+N_CKE cycles after the start edge, and no command is ever issued while cke_o or mem_rst_n_o is low.
- R4: Each rank receives four one-cycle mode-register writes with cmd_ba_o = 2, 3, 1, 0, in that order, spaced exactly T_MRD_CYC cycles apart. The command after a rank's last write follows it by N_DLL+1 cycles.
- R5: MR0 address: bits[1:0] burst control, bit 2 = 0, bit 3 = 1, bits[6:4] CAS latency, bit 7 = 0, bit 8 = 1, bits[11:9] write recovery, bit 12 precharge power-down.
- R6: MR2 address: bits[5:3] CAS write latency, bit 6 auto self-refresh, bit 7 temperature range, bits[10:9] dynamic termination, all other bits 0. MR3 address: bits[1:0] MPR location, bit 2 MPR enable, all other bits 0.
- R7: MR1 address: drive strength bit 1 to bit 5 and bit 0 to bit 1, termination code bits 2/1/0 to bits 9/6/2, TDQS to bit 11, output disable to bit 12, all other bits 0.
- R8: The termination code is cfg_rtt_qr_i for a rank of a quad-rank registered DIMM and cfg_rtt_nom_i otherwise. It is forced to 0 on odd ranks when max_dimms_i=4, on ranks 1 and 5 when max_dimms_i=3, and on odd ranks of a quad-rank DIMM (qr_dimm_i bit = rank/2).
- R9: With rdimm_i=1, every present rank is programmed in ascending order while init_en_o=1.
- R10: With rdimm_i=0, only the lowest present rank is programmed while init_en_o=1. The remaining present ranks are programmed in ascending order with init_en_o=0, with no ZQ command after them.
- R11: After the init-phase ranks, two ZQ calibration-long commands (cmd_zq_o=1, cmd_ba_o=0, cmd_addr_o=13'h400) go to the even rank and then the odd rank of the lowest present rank's pair. They are spaced T_ZQINIT_CYC+1 cycles apart, and the next command or the end follows the second one by the same gap.
- R12: With an all-zero presence mask, no command is issued and done_o rises N_INIT+N_RST+N_CKE cycles after the start edge.
- R13: A start strobe while the sequence is running has no effect on the outputs.
- R14: done_o stays high, with mem_rst_n_o=1, cke_o=1 and init_en_o=0, until the next start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only in idle |
| cs_present_i | input | NUM_CS | Rank presence mask |
| rdimm_i | input | 1 | 1 = registered DIMMs, 0 = unbuffered |
| qr_dimm_i | input | NUM_CS/2 | Quad-rank flag per DIMM slot |
| max_dimms_i | input | 3 | DIMMs the channel supports |
| cfg_bl_i | input | 2 | Burst control |
| cfg_cl_i | input | 3 | CAS latency code |
| cfg_wr_i | input | 3 | Write recovery code |
| cfg_ppd_i | input | 1 | Precharge power-down mode |
| cfg_cwl_i | input | 3 | CAS write latency code |
| cfg_asr_i | input | 1 | Auto self-refresh |
| cfg_srt_i | input | 1 | Self-refresh temperature range |
| cfg_rtt_wr_i | input | 2 | Dynamic write termination |
| cfg_mpr_loc_i | input | 2 | MPR location |
| cfg_mpr_en_i | input | 1 | MPR enable |
| cfg_dic_i | input | 2 | Output drive strength |
| cfg_rtt_nom_i | input | 3 | Nominal termination code |
| cfg_rtt_qr_i | input | 3 | Nominal termination for quad-rank registered DIMMs |
| cfg_qoff_i | input | 1 | Output buffer disable |
| cfg_tdqs_i | input | 1 | TDQS enable |
| init_en_o | output | 1 | Init phase active |
| mem_rst_n_o | output | 1 | Memory reset, active low |
| cke_o | output | 1 | Clock enable |
| cmd_valid_o | output | 1 | Command strobe, one cycle per command |
| cmd_zq_o | output | 1 | 1 = ZQ calibration long, 0 = mode-register set |
| cmd_ba_o | output | 3 | Bank address |
| cmd_addr_o | output | 13 | Address |
| cmd_cs_o | output | log2(NUM_CS) | Target rank |
| done_o | output | 1 | Sequence complete, held until next start |

## Verification
The hardest case to reach is the unbuffered flow, where the init phase closes between the ZQ pair and the remaining ranks. In that flow the same mode-register sequence must be replayed with init_en_o low, and the termination rules must pick different codes per rank. The stimulus uses a sparse presence mask starting at an odd rank with max_dimms_i=3, so the ZQ pair targets a pair below the first programmed rank and one later rank has its termination forced off. A separate registered run mixes a quad-rank slot with a four-DIMM channel so that the alternate code and both zeroing rules appear, and a start pulse is injected during the reset wait.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_RST, S_CKE, S_MRS, S_GAP, S_DLL, S_ZQ, S_ZQW
  } seq_state_e;

  // issue order within a rank
  typedef enum logic [1:0] {
    STEP_MR2 = 2'd0, STEP_MR3 = 2'd1, STEP_MR1 = 2'd2, STEP_MR0 = 2'd3
  } mr_step_e;

  typedef struct packed {
    logic [1:0] bl;
    logic [2:0] cl;
    logic [2:0] wr;
    logic       ppd;
    logic [2:0] cwl;
    logic       asr;
    logic       srt;
    logic [1:0] rtt_wr;
    logic [1:0] mpr_loc;
    logic       mpr_en;
    logic [1:0] dic;
    logic [2:0] rtt_nom;
    logic [2:0] rtt_qr;
    logic       qoff;
    logic       tdqs;
  } mr_cfg_t;

  function automatic int ns_to_cyc(int ns, int period_ps);
    int c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr3_wait_timer.sv
module ddr3_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ddr3_rank_pick.sv
module ddr3_rank_pick #(
  parameter int NUM_CS = 8,
  parameter int CS_W   = 3
) (
  input  logic [NUM_CS-1:0] mask_i,
  input  logic [CS_W:0]     from_i,
  output logic              found_o,
  output logic [CS_W-1:0]   idx_o
);
  // lowest present rank at or above from_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (mask_i[i] && ((CS_W+1)'(i) >= from_i)) begin
        found_o = 1'b1;
        idx_o   = CS_W'(i);
      end
    end
  end
endmodule

// File: rtl/ddr3_mr_encode.sv
module ddr3_mr_encode
  import ddr3_init_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CS_W   = 3,
  parameter int DIMM_N = 4
) (
  input  mr_step_e          step_i,
  input  logic [CS_W-1:0]   cs_i,
  input  mr_cfg_t           cfg_i,
  input  logic              rdimm_i,
  input  logic [DIMM_N-1:0] qr_dimm_i,
  input  logic [2:0]        max_dimms_i,
  output logic [2:0]        ba_o,
  output logic [12:0]       addr_o
);
  logic       qr_hit;
  logic       rtt_off;
  logic [2:0] rtt;

  assign qr_hit  = qr_dimm_i[cs_i[CS_W-1:1]];
  assign rtt_off = ((max_dimms_i == 3'd4) && cs_i[0]) ||
                   ((max_dimms_i == 3'd3) && ((cs_i == CS_W'(1)) || (cs_i == CS_W'(5)))) ||
                   (qr_hit && cs_i[0]);
  assign rtt     = rtt_off ? 3'd0 : ((rdimm_i && qr_hit) ? cfg_i.rtt_qr : cfg_i.rtt_nom);

  always_comb begin
    addr_o = '0;
    ba_o   = 3'd0;
    unique case (step_i)
      STEP_MR0: begin
        ba_o          = 3'd0;
        addr_o[1:0]   = cfg_i.bl;
        addr_o[3]     = 1'b1;
        addr_o[6:4]   = cfg_i.cl;
        addr_o[8]     = 1'b1;
        addr_o[11:9]  = cfg_i.wr;
        addr_o[12]    = cfg_i.ppd;
      end
      STEP_MR1: begin
        ba_o          = 3'd1;
        addr_o[1]     = cfg_i.dic[0];
        addr_o[5]     = cfg_i.dic[1];
        addr_o[2]     = rtt[0];
        addr_o[6]     = rtt[1];
        addr_o[9]     = rtt[2];
        addr_o[11]    = cfg_i.tdqs;
        addr_o[12]    = cfg_i.qoff;
      end
      STEP_MR2: begin
        ba_o          = 3'd2;
        addr_o[5:3]   = cfg_i.cwl;
        addr_o[6]     = cfg_i.asr;
        addr_o[7]     = cfg_i.srt;
        addr_o[10:9]  = cfg_i.rtt_wr;
      end
      STEP_MR3: begin
        ba_o          = 3'd3;
        addr_o[1:0]   = cfg_i.mpr_loc;
        addr_o[2]     = cfg_i.mpr_en;
      end
    endcase
  end
endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int NUM_CS        = 8,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int T_INIT_NS     = 200000,
  parameter int T_RST_NS      = 500000,
  parameter int T_CKE_NS      = 360,
  parameter int T_DLL_NS      = 500000,
  parameter int T_MRD_CYC     = 4,
  parameter int T_ZQINIT_CYC  = 512,
  localparam int CS_W         = $clog2(NUM_CS),
  localparam int DIMM_N       = NUM_CS / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NUM_CS-1:0] cs_present_i,
  input  logic              rdimm_i,
  input  logic [DIMM_N-1:0] qr_dimm_i,
  input  logic [2:0]        max_dimms_i,
  input  logic [1:0]        cfg_bl_i,
  input  logic [2:0]        cfg_cl_i,
  input  logic [2:0]        cfg_wr_i,
  input  logic              cfg_ppd_i,
  input  logic [2:0]        cfg_cwl_i,
  input  logic              cfg_asr_i,
  input  logic              cfg_srt_i,
  input  logic [1:0]        cfg_rtt_wr_i,
  input  logic [1:0]        cfg_mpr_loc_i,
  input  logic              cfg_mpr_en_i,
  input  logic [1:0]        cfg_dic_i,
  input  logic [2:0]        cfg_rtt_nom_i,
  input  logic [2:0]        cfg_rtt_qr_i,
  input  logic              cfg_qoff_i,
  input  logic              cfg_tdqs_i,
  output logic              init_en_o,
  output logic              mem_rst_n_o,
  output logic              cke_o,
  output logic              cmd_valid_o,
  output logic              cmd_zq_o,
  output logic [2:0]        cmd_ba_o,
  output logic [12:0]       cmd_addr_o,
  output logic [CS_W-1:0]   cmd_cs_o,
  output logic              done_o
);
  localparam int N_INIT = ns_to_cyc(T_INIT_NS, CLK_PERIOD_PS);
  localparam int N_RST  = ns_to_cyc(T_RST_NS, CLK_PERIOD_PS);
  localparam int N_CKE  = ns_to_cyc(T_CKE_NS, CLK_PERIOD_PS);
  localparam int N_DLL  = ns_to_cyc(T_DLL_NS, CLK_PERIOD_PS);
  localparam int N_MAX  = max_of(max_of(max_of(N_INIT, N_RST), max_of(N_CKE, N_DLL)),
                                 max_of(T_MRD_CYC, T_ZQINIT_CYC));
  localparam int TMR_W  = $clog2(N_MAX + 1);
  localparam logic [12:0] ZQCL_ADDR = 13'h400;

  seq_state_e      state_q, state_d;
  mr_step_e        step_q, step_d;
  logic [CS_W-1:0] cs_q, cs_d, first_q, first_d;
  logic            post_q, post_d, zq_q, zq_d;
  logic            rel_q, rel_d, cke_q, cke_d, done_q, done_d;

  logic             tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  logic [CS_W:0]    pick_from;
  logic             pick_found;
  logic [CS_W-1:0]  pick_idx;
  mr_cfg_t          cfg;
  logic [2:0]       enc_ba;
  logic [12:0]      enc_addr;

  assign cfg = '{bl: cfg_bl_i, cl: cfg_cl_i, wr: cfg_wr_i, ppd: cfg_ppd_i,
                 cwl: cfg_cwl_i, asr: cfg_asr_i, srt: cfg_srt_i, rtt_wr: cfg_rtt_wr_i,
                 mpr_loc: cfg_mpr_loc_i, mpr_en: cfg_mpr_en_i, dic: cfg_dic_i,
                 rtt_nom: cfg_rtt_nom_i, rtt_qr: cfg_rtt_qr_i, qoff: cfg_qoff_i,
                 tdqs: cfg_tdqs_i};

  ddr3_wait_timer #(.W(TMR_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_exp)
  );

  always_comb begin
    if (state_q == S_CKE)      pick_from = '0;
    else if (state_q == S_ZQW) pick_from = {1'b0, first_q} + 1'b1;
    else                       pick_from = {1'b0, cs_q} + 1'b1;
  end

  ddr3_rank_pick #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_pick (
    .mask_i  (cs_present_i),
    .from_i  (pick_from),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  ddr3_mr_encode #(.NUM_CS(NUM_CS), .CS_W(CS_W), .DIMM_N(DIMM_N)) u_enc (
    .step_i      (step_q),
    .cs_i        (cs_q),
    .cfg_i       (cfg),
    .rdimm_i     (rdimm_i),
    .qr_dimm_i   (qr_dimm_i),
    .max_dimms_i (max_dimms_i),
    .ba_o        (enc_ba),
    .addr_o      (enc_addr)
  );

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    cs_d     = cs_q;
    first_d  = first_q;
    post_d   = post_q;
    zq_d     = zq_q;
    rel_d    = rel_q;
    cke_d    = cke_q;
    done_d   = done_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d  = S_PWR;
        rel_d    = 1'b0;
        cke_d    = 1'b0;
        done_d   = 1'b0;
        post_d   = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(N_INIT - 1);
      end
      S_PWR: if (tmr_exp) begin
        state_d  = S_RST;
        rel_d    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(N_RST - 1);
      end
      S_RST: if (tmr_exp) begin
        state_d  = S_CKE;
        cke_d    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(N_CKE - 1);
      end
      S_CKE: if (tmr_exp) begin
        if (pick_found) begin
          cs_d    = pick_idx;
          first_d = pick_idx;
          step_d  = STEP_MR2;
          state_d = S_MRS;
        end else begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end
      end
      S_MRS: begin
        tmr_load = 1'b1;
        if (step_q == STEP_MR0) begin
          state_d = S_DLL;
          tmr_val = TMR_W'(N_DLL - 1);
        end else begin
          state_d = S_GAP;
          tmr_val = TMR_W'(T_MRD_CYC - 2);
        end
      end
      S_GAP: if (tmr_exp) begin
        step_d  = mr_step_e'(step_q + 2'd1);
        state_d = S_MRS;
      end
      S_DLL: if (tmr_exp) begin
        if (!post_q && !rdimm_i) begin
          state_d = S_ZQ;
          zq_d    = 1'b0;
        end else if (pick_found) begin
          cs_d    = pick_idx;
          step_d  = STEP_MR2;
          state_d = S_MRS;
        end else if (post_q) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = S_ZQ;
          zq_d    = 1'b0;
        end
      end
      S_ZQ: begin
        state_d  = S_ZQW;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(T_ZQINIT_CYC - 1);
      end
      S_ZQW: if (tmr_exp) begin
        if (!zq_q) begin
          zq_d    = 1'b1;
          state_d = S_ZQ;
        end else begin
          post_d = 1'b1;
          if (!rdimm_i && pick_found) begin
            cs_d    = pick_idx;
            step_d  = STEP_MR2;
            state_d = S_MRS;
          end else begin
            state_d = S_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= STEP_MR2;
      cs_q    <= '0;
      first_q <= '0;
      post_q  <= 1'b0;
      zq_q    <= 1'b0;
      rel_q   <= 1'b0;
      cke_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      cs_q    <= cs_d;
      first_q <= first_d;
      post_q  <= post_d;
      zq_q    <= zq_d;
      rel_q   <= rel_d;
      cke_q   <= cke_d;
      done_q  <= done_d;
    end
  end

  assign init_en_o   = (state_q != S_IDLE) && !post_q;
  assign mem_rst_n_o = rel_q;
  assign cke_o       = cke_q;
  assign done_o      = done_q;
  assign cmd_valid_o = (state_q == S_MRS) || (state_q == S_ZQ);
  assign cmd_zq_o    = (state_q == S_ZQ);
  assign cmd_ba_o    = (state_q == S_MRS) ? enc_ba : 3'd0;
  assign cmd_addr_o  = (state_q == S_MRS) ? enc_addr :
                       (state_q == S_ZQ)  ? ZQCL_ADDR : 13'd0;
  assign cmd_cs_o    = (state_q == S_ZQ) ? {first_q[CS_W-1:1], zq_q} : cs_q;
endmodule

// File: rtl/ddr3_init_seq_chk.sv
module ddr3_init_seq_chk #(
  parameter int T_MRD_CYC = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_o,
  input logic       cmd_zq_o,
  input logic [2:0] cmd_ba_o,
  input logic       init_en_o,
  input logic       mem_rst_n_o,
  input logic       cke_o,
  input logic       done_o
);
  logic [2:0] last_ba;
  logic [7:0] gap_cnt;

  function automatic logic [2:0] pred_ba(logic [2:0] ba);
    case (ba)
      3'd3:    return 3'd2;
      3'd1:    return 3'd3;
      3'd0:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_ba <= 3'd0;
      gap_cnt <= 8'd0;
    end else begin
      if (cmd_valid_o && !cmd_zq_o) last_ba <= cmd_ba_o;
      if (cmd_valid_o)              gap_cnt <= 8'd1;
      else if (gap_cnt != 8'hff)    gap_cnt <= gap_cnt + 8'd1;
    end
  end

  p_cmd_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  p_mr_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_zq_o && cmd_ba_o != 3'd2) |-> (last_ba == pred_ba(cmd_ba_o)));

  p_mr_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_zq_o && cmd_ba_o != 3'd2) |-> (gap_cnt == 8'(T_MRD_CYC)));

  p_cmd_needs_cke_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cke_o && mem_rst_n_o));

  p_cke_after_rst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |-> mem_rst_n_o);

  p_zq_in_init_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_zq_o) |-> init_en_o);

  p_done_quiet_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!cmd_valid_o && !init_en_o && mem_rst_n_o && cke_o));
endmodule

bind ddr3_init_seq ddr3_init_seq_chk #(.T_MRD_CYC(T_MRD_CYC)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_o (cmd_valid_o),
  .cmd_zq_o    (cmd_zq_o),
  .cmd_ba_o    (cmd_ba_o),
  .init_en_o   (init_en_o),
  .mem_rst_n_o (mem_rst_n_o),
  .cke_o       (cke_o),
  .done_o      (done_o)
);

// File: tb/ddr3_init_seq_tb_top.sv
`timescale 1ns/1ps
module ddr3_init_seq_tb_top;
  localparam int NCS    = 8;
  localparam int PER_PS = 5000;
  localparam int TI_NS  = 200;
  localparam int TR_NS  = 300;
  localparam int TC_NS  = 40;
  localparam int TD_NS  = 150;
  localparam int TMRD   = 4;
  localparam int TZQ    = 16;
  localparam int N_I    = TI_NS * 1000 / PER_PS;
  localparam int N_R    = TR_NS * 1000 / PER_PS;
  localparam int N_C    = TC_NS * 1000 / PER_PS;
  localparam int N_D    = TD_NS * 1000 / PER_PS;
  localparam int T_FIRST = N_I + N_R + N_C;

  typedef struct {
    bit        zq;
    bit [2:0]  ba;
    bit [12:0] addr;
    bit [2:0]  cs;
    bit        ien;
    int        gap;
  } exp_t;

  exp_t exp_q[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] mask = '0;
  logic rdimm = 1'b0;
  logic [3:0] qr = '0;
  logic [2:0] maxd = 3'd2;
  logic [1:0] c_bl = '0, c_rttwr = '0, c_mprloc = '0, c_dic = '0;
  logic [2:0] c_cl = '0, c_wr = '0, c_cwl = '0, c_rtt = '0, c_rttqr = '0;
  logic c_ppd = 0, c_asr = 0, c_srt = 0, c_mpren = 0, c_qoff = 0, c_tdqs = 0;

  logic        init_en, mrst_n, cke, cvalid, czq, done;
  logic [2:0]  cba, ccs;
  logic [12:0] caddr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int c0 = 0;
  int last_cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr3_init_seq #(
    .NUM_CS(NCS), .CLK_PERIOD_PS(PER_PS), .T_INIT_NS(TI_NS), .T_RST_NS(TR_NS),
    .T_CKE_NS(TC_NS), .T_DLL_NS(TD_NS), .T_MRD_CYC(TMRD), .T_ZQINIT_CYC(TZQ)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cs_present_i(mask),
    .rdimm_i(rdimm), .qr_dimm_i(qr), .max_dimms_i(maxd),
    .cfg_bl_i(c_bl), .cfg_cl_i(c_cl), .cfg_wr_i(c_wr), .cfg_ppd_i(c_ppd),
    .cfg_cwl_i(c_cwl), .cfg_asr_i(c_asr), .cfg_srt_i(c_srt), .cfg_rtt_wr_i(c_rttwr),
    .cfg_mpr_loc_i(c_mprloc), .cfg_mpr_en_i(c_mpren), .cfg_dic_i(c_dic),
    .cfg_rtt_nom_i(c_rtt), .cfg_rtt_qr_i(c_rttqr), .cfg_qoff_i(c_qoff), .cfg_tdqs_i(c_tdqs),
    .init_en_o(init_en), .mem_rst_n_o(mrst_n), .cke_o(cke), .cmd_valid_o(cvalid),
    .cmd_zq_o(czq), .cmd_ba_o(cba), .cmd_addr_o(caddr), .cmd_cs_o(ccs), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic bit [12:0] e_mr0();
    bit [12:0] a = '0;
    a[1:0] = c_bl; a[3] = 1'b1; a[6:4] = c_cl; a[8] = 1'b1; a[11:9] = c_wr; a[12] = c_ppd;
    return a;
  endfunction

  function automatic bit [12:0] e_mr2();
    bit [12:0] a = '0;
    a[5:3] = c_cwl; a[6] = c_asr; a[7] = c_srt; a[10:9] = c_rttwr;
    return a;
  endfunction

  function automatic bit [12:0] e_mr3();
    bit [12:0] a = '0;
    a[1:0] = c_mprloc; a[2] = c_mpren;
    return a;
  endfunction

  function automatic bit [12:0] e_mr1(input int cs);
    bit [12:0] a = '0;
    bit [2:0] r;
    bit q = qr[cs / 2];
    r = (rdimm && q) ? c_rttqr : c_rtt;
    if (maxd == 3'd4 && (cs % 2) == 1) r = 3'd0;
    if (maxd == 3'd3 && (cs == 1 || cs == 5)) r = 3'd0;
    if (q && (cs % 2) == 1) r = 3'd0;
    a[1] = c_dic[0]; a[5] = c_dic[1];
    a[2] = r[0]; a[6] = r[1]; a[9] = r[2];
    a[11] = c_tdqs; a[12] = c_qoff;
    return a;
  endfunction

  function automatic exp_t mk(input bit zq, input bit [2:0] ba, input bit [12:0] addr,
                              input int cs, input bit ien, input int gap);
    exp_t e;
    e.zq = zq; e.ba = ba; e.addr = addr; e.cs = 3'(cs); e.ien = ien; e.gap = gap;
    return e;
  endfunction

  task automatic push_rank(input int cs, input int gap, input bit ien);
    exp_q.push_back(mk(0, 3'd2, e_mr2(), cs, ien, gap));
    exp_q.push_back(mk(0, 3'd3, e_mr3(), cs, ien, TMRD));
    exp_q.push_back(mk(0, 3'd1, e_mr1(cs), cs, ien, TMRD));
    exp_q.push_back(mk(0, 3'd0, e_mr0(), cs, ien, TMRD));
  endtask

  // expected command stream from the requirements
  task automatic plan_run();
    int first = -1;
    int gap = T_FIRST;
    for (int i = 0; i < NCS; i++) if (mask[i] && first < 0) first = i;
    if (first < 0) return;
    for (int i = first; i < NCS; i++) begin
      if (mask[i] && (rdimm || i == first)) begin
        push_rank(i, gap, 1'b1);
        gap = N_D + 1;
      end
    end
    exp_q.push_back(mk(1, 3'd0, 13'h400, first & ~1, 1'b1, gap));
    exp_q.push_back(mk(1, 3'd0, 13'h400, first | 1, 1'b1, TZQ + 1));
    gap = TZQ + 1;
    if (!rdimm) begin
      for (int i = first + 1; i < NCS; i++) begin
        if (mask[i]) begin
          push_rank(i, gap, 1'b0);
          gap = N_D + 1;
        end
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cvalid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R12", "unexpected command bank", int'(cba), 0);
      end else begin
        exp_t e;
        string tb;
        e = exp_q.pop_front();
        tb = e.zq ? "R11" : (e.ba == 3'd0) ? "R5" : (e.ba == 3'd1) ? "R7/R8" : "R6";
        chk(czq == e.zq, "R11", "command kind", int'(czq), int'(e.zq));
        chk(cba == e.ba, "R4", "bank", int'(cba), int'(e.ba));
        chk(caddr == e.addr, tb, "address", int'(caddr), int'(e.addr));
        chk(ccs == e.cs, e.ien ? "R9" : "R10", "rank", int'(ccs), int'(e.cs));
        chk(init_en == e.ien, "R10", "init phase", int'(init_en), int'(e.ien));
        chk((cyc - last_cyc) == e.gap, "R3/R4", "gap", cyc - last_cyc, e.gap);
      end
      last_cyc = cyc;
    end
  end

  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    c0 = cyc;
    last_cyc = cyc;
  endtask

  task automatic at_off(input int k);
    while ((cyc - c0) < k) @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, req, "done reached", int'(done), 1);
    chk(exp_q.size() == 0, req, "commands left", exp_q.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state and idle before the first start
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(mrst_n == 1'b0, "R1", "mem reset", int'(mrst_n), 0);
    chk(cke == 1'b0, "R1", "cke", int'(cke), 0);
    chk(init_en == 1'b0 && done == 1'b0 && cvalid == 1'b0, "R1", "idle flags",
        int'({init_en, done, cvalid}), 0);

    // run A: registered, quad-rank slot 2, four-DIMM channel
    rdimm = 1'b1; mask = 8'b0011_0110; qr = 4'b0100; maxd = 3'd4;
    c_bl = 2'b01; c_cl = 3'b101; c_wr = 3'b110; c_ppd = 1'b1; c_cwl = 3'b011;
    c_asr = 1'b1; c_srt = 1'b0; c_rttwr = 2'b10; c_mprloc = 2'b00; c_mpren = 1'b0;
    c_dic = 2'b01; c_rtt = 3'b011; c_rttqr = 3'b101; c_qoff = 1'b0; c_tdqs = 1'b1;
    plan_run();
    do_start();
    chk(init_en == 1'b1, "R2", "init phase on", int'(init_en), 1);
    at_off(N_I - 1);
    chk(mrst_n == 1'b0, "R2", "reset held", int'(mrst_n), 0);
    at_off(N_I);
    chk(mrst_n == 1'b1, "R2", "reset released", int'(mrst_n), 1);
    at_off(N_I + N_R - 1);
    chk(cke == 1'b0, "R3", "cke low", int'(cke), 0);
    at_off(N_I + N_R);
    chk(cke == 1'b1, "R3", "cke high", int'(cke), 1);
    wait_done("R9");
    repeat (20) @(negedge clk);
    chk(done == 1'b1 && mrst_n == 1'b1 && cke == 1'b1 && init_en == 1'b0, "R14",
        "held after done", int'({done, mrst_n, cke, init_en}), 4'b1110);

    // run B: unbuffered, three-DIMM channel, start pulse while busy
    rdimm = 1'b0; mask = 8'b1010_1000; qr = 4'b0000; maxd = 3'd3;
    c_bl = 2'b10; c_cl = 3'b010; c_wr = 3'b001; c_ppd = 1'b0; c_cwl = 3'b101;
    c_asr = 1'b0; c_srt = 1'b1; c_rttwr = 2'b01; c_mprloc = 2'b10; c_mpren = 1'b0;
    c_dic = 2'b10; c_rtt = 3'b110; c_rttqr = 3'b001; c_qoff = 1'b1; c_tdqs = 1'b0;
    plan_run();
    do_start();
    chk(done == 1'b0, "R14", "done cleared", int'(done), 0);
    chk(mrst_n == 1'b0, "R2", "reset reasserted", int'(mrst_n), 0);
    at_off(N_I + 5);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk(mrst_n == 1'b1 && cke == 1'b0, "R13", "busy start ignored",
        int'({mrst_n, cke}), 2'b10);
    wait_done("R10");

    // run C: empty mask
    mask = 8'h00;
    plan_run();
    do_start();
    at_off(T_FIRST - 1);
    chk(done == 1'b0 && cke == 1'b1, "R12", "before done", int'({done, cke}), 2'b01);
    at_off(T_FIRST);
    chk(done == 1'b1, "R12", "done time", int'(done), 1);
    wait_done("R12");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule